// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block holds the operating mode of a small microcontroller core and moves it between six modes: active, sleep, standby, watch, subsleep and subactive. A one-cycle SLEEP strobe from the core decides the next mode from three configuration bits: standby select, low-speed-on and timer watch enable. Interrupt requests bring the block out of a low-power mode. Which requests are allowed to do so depends on the mode the block is in. Every requested source must also be enabled, and the global mask must be clear.

When an interrupt ends a low-power mode, the block gives a one-cycle pulse that tells the core to start interrupt exception handling. In subactive mode the block also produces a clock enable for the core. This enable is the watch clock divided by 2, 4 or 8. The block is clocked by the watch clock. Oscillator settling, interrupt priority and the core are outside the block.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: With rst_ni low, mode_o is 0 (active), wake_o is 0 and sub_ce_o is 0, whatever mode was held before. Reset is asynchronous.
- R2: Source bit layout of irq_req_i and irq_en_i: bit 0 is timer A, bit 1 is timer C, bit 2 is timer G, bits 7:3 are external IRQ0..IRQ4 and bits 15:8 are wake pins 0..7. A source can end a low-power mode only when imask_i is 0 and its own enable bit is 1. Otherwise the mode is held.
- R3: In active mode (code 0), a SLEEP strobe selects the next mode as follows:
  - standby select=1 and watch enable=1: watch (3).
  - standby select=1 and watch enable=0: standby (2).
  - standby select=0, low-speed-on=1 and watch enable=1: subsleep (4).
  - any other setting: sleep (1).
- R4: In sleep mode (1), any enabled and unmasked source returns the block to active.
- R5: Standby mode (2) is not left on an interrupt. Only reset ends it.
- R6: Watch mode (3) is left only on timer A, IRQ0 or a wake pin. The block goes to subactive (5) if low-speed-on is 1 and to active otherwise. Other sources are ignored.
- R7: In subsleep mode (4), any of the 16 sources moves the block to subactive.
- R8: In subactive mode, a SLEEP strobe goes to watch when standby select=1 and watch enable=1. It goes to subsleep when standby select=0, low-speed-on=1 and watch enable=1. Any other setting leaves the block in subactive.
- R9: wake_o is high for exactly one cycle, on the same edge where an interrupt ends a low-power mode. It is not raised in any other case.
- R10: In subactive mode, sub_ce_o pulses once every 2, 4 or 8 cycles for div_sel_i values 0, 1 and 2. Value 3 also gives once every 8 cycles. In any other mode, sub_ce_o stays 0.
- R11: A SLEEP strobe in a low-power mode is ignored. Interrupt requests in active or subactive mode change neither the mode nor wake_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watch clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | One-cycle SLEEP instruction strobe |
| ssby_i | input | 1 | Standby select |
| lson_i | input | 1 | Low-speed-on |
| tw_en_i | input | 1 | Timer watch enable |
| div_sel_i | input | 2 | Subactive clock divider select |
| imask_i | input | 1 | Global interrupt mask, 1 blocks all wakes |
| irq_req_i | input | 16 | Per-source interrupt requests |
| irq_en_i | input | 16 | Per-source interrupt enables |
| mode_o | output | 3 | Current mode code |
| wake_o | output | 1 | Start of interrupt exception handling |
| sub_ce_o | output | 1 | Divided core clock enable in subactive |

## Verification
The hardest case is the watch-mode source filter. A non-watch source must be refused in watch mode, yet the same source must be accepted one step later in subsleep. Reaching that point needs a chain of SLEEP strobes with exact bit combinations. The bench walks one stateful vector sequence that enters watch, subsleep and subactive several times by different routes. Along the way it presents rejected sources, masked requests and disabled enables before the request that is allowed to wake the block.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    MODE_ACTIVE   = 3'd0,
    MODE_SLEEP    = 3'd1,
    MODE_STANDBY  = 3'd2,
    MODE_WATCH    = 3'd3,
    MODE_SUBSLEEP = 3'd4,
    MODE_SUBACT   = 3'd5
  } lpm_mode_e;

  function automatic logic is_low_power(lpm_mode_e m);
    return (m == MODE_SLEEP) || (m == MODE_STANDBY) ||
           (m == MODE_WATCH) || (m == MODE_SUBSLEEP);
  endfunction
endpackage

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
  import lpm_pkg::*;
#(
  parameter int unsigned N_TIMER = 3,
  parameter int unsigned N_IRQ   = 5,
  parameter int unsigned N_WKP   = 8,
  localparam int unsigned SRC_N  = N_TIMER + N_IRQ + N_WKP
) (
  input  lpm_mode_e        mode_i,
  input  logic             imask_i,
  input  logic [SRC_N-1:0] irq_i,
  input  logic [SRC_N-1:0] en_i,
  output logic             fire_o
);
  localparam int unsigned WKP_LO = N_TIMER + N_IRQ;

  logic [SRC_N-1:0] watch_ok;
  logic [SRC_N-1:0] live;

  // watch mode accepts timer A (bit 0), IRQ0 and the wake pins
  for (genvar g = 0; g < SRC_N; g++) begin : g_watch_map
    if (g == 0 || g == N_TIMER || g >= WKP_LO) begin : g_on
      assign watch_ok[g] = 1'b1;
    end else begin : g_off
      assign watch_ok[g] = 1'b0;
    end
  end

  assign live = irq_i & en_i & ~{SRC_N{imask_i}};

  always_comb begin
    unique case (mode_i)
      MODE_SLEEP, MODE_SUBSLEEP: fire_o = |live;
      MODE_WATCH:                fire_o = |(live & watch_ok);
      default:                   fire_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_sleep_decode.sv
module lpm_sleep_decode
  import lpm_pkg::*;
(
  input  logic      from_active_i,
  input  logic      ssby_i,
  input  logic      lson_i,
  input  logic      tw_en_i,
  output lpm_mode_e next_o,
  output logic      take_o
);
  always_comb begin
    next_o = MODE_ACTIVE;
    take_o = 1'b0;
    if (ssby_i && tw_en_i) begin
      next_o = MODE_WATCH;
      take_o = 1'b1;
    end else if (!ssby_i && lson_i && tw_en_i) begin
      next_o = MODE_SUBSLEEP;
      take_o = 1'b1;
    end else if (from_active_i) begin
      next_o = ssby_i ? MODE_STANDBY : MODE_SLEEP;
      take_o = 1'b1;
    end
  end
endmodule

// File: rtl/lpm_subclk_div.sv
module lpm_subclk_div #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ce_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;

  // select code k divides by 2^(k+1), capped at the counter span
  function automatic logic [CNT_W-1:0] low_ones(logic [SEL_W-1:0] s);
    int e;
    e = int'(s) + 1;
    if (e > int'(CNT_W)) e = int'(CNT_W);
    low_ones = '0;
    for (int i = 0; i < int'(CNT_W); i++) begin
      if (i < e) low_ones[i] = 1'b1;
    end
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign need = low_ones(sel_i);
  assign ce_o = run_i && ((cnt_q & need) == need);

  AST_CE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |=> !ce_o); // R10
endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned N_TIMER   = 3,
  parameter int unsigned N_IRQ     = 5,
  parameter int unsigned N_WKP     = 8,
  parameter int unsigned DIV_CNT_W = 3,
  parameter int unsigned DIV_SEL_W = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             sleep_i,
  input  logic                             ssby_i,
  input  logic                             lson_i,
  input  logic                             tw_en_i,
  input  logic [DIV_SEL_W-1:0]             div_sel_i,
  input  logic                             imask_i,
  input  logic [N_TIMER+N_IRQ+N_WKP-1:0]   irq_req_i,
  input  logic [N_TIMER+N_IRQ+N_WKP-1:0]   irq_en_i,
  output logic [2:0]                       mode_o,
  output logic                             wake_o,
  output logic                             sub_ce_o
);
  lpm_mode_e mode_q, mode_d;
  logic      wake_q, wake_d;
  logic      fire;
  lpm_mode_e slp_next;
  logic      slp_take;

  lpm_wake_filter #(
    .N_TIMER(N_TIMER), .N_IRQ(N_IRQ), .N_WKP(N_WKP)
  ) u_filter (
    .mode_i (mode_q),
    .imask_i(imask_i),
    .irq_i  (irq_req_i),
    .en_i   (irq_en_i),
    .fire_o (fire)
  );

  lpm_sleep_decode u_sdec (
    .from_active_i(mode_q == MODE_ACTIVE),
    .ssby_i       (ssby_i),
    .lson_i       (lson_i),
    .tw_en_i      (tw_en_i),
    .next_o       (slp_next),
    .take_o       (slp_take)
  );

  always_comb begin
    mode_d = mode_q;
    wake_d = 1'b0;
    unique case (mode_q)
      MODE_ACTIVE, MODE_SUBACT: begin
        if (sleep_i && slp_take) mode_d = slp_next;
      end
      MODE_SLEEP: begin
        if (fire) begin
          mode_d = MODE_ACTIVE;
          wake_d = 1'b1;
        end
      end
      MODE_WATCH: begin
        if (fire) begin
          mode_d = lson_i ? MODE_SUBACT : MODE_ACTIVE;
          wake_d = 1'b1;
        end
      end
      MODE_SUBSLEEP: begin
        if (fire) begin
          mode_d = MODE_SUBACT;
          wake_d = 1'b1;
        end
      end
      MODE_STANDBY: mode_d = MODE_STANDBY;
      default:      mode_d = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ACTIVE;
      wake_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wake_q <= wake_d;
    end
  end

  lpm_subclk_div #(
    .CNT_W(DIV_CNT_W), .SEL_W(DIV_SEL_W)
  ) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (mode_q == MODE_SUBACT),
    .sel_i (div_sel_i),
    .ce_o  (sub_ce_o)
  );

  assign mode_o = mode_q;
  assign wake_o = wake_q;

  AST_WAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R9
  AST_WAKE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (mode_o == MODE_ACTIVE || mode_o == MODE_SUBACT)); // R9
  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_low_power(mode_q) && imask_i) |=> $stable(mode_q)); // R2
  AST_STANDBY_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STANDBY) |=> (mode_q == MODE_STANDBY)); // R5
  AST_WATCH_LSON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WATCH && lson_i) |=> (mode_q == MODE_WATCH || mode_q == MODE_SUBACT)); // R6
  AST_SUBSLEEP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SUBSLEEP) |=> (mode_q == MODE_SUBSLEEP || mode_q == MODE_SUBACT)); // R7
  AST_SUBACT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SUBACT) |=> (mode_q == MODE_SUBACT || mode_q == MODE_WATCH ||
                                 mode_q == MODE_SUBSLEEP)); // R8
  AST_CE_SUBACT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_ce_o |-> (mode_o == MODE_SUBACT)); // R10
endmodule

// File: tb/lpm_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_mode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sleep_i = 1'b0, ssby_i = 1'b0, lson_i = 1'b0, tw_en_i = 1'b0;
  logic [1:0]  div_sel_i = 2'd0;
  logic        imask_i = 1'b0;
  logic [15:0] irq_req_i = '0, irq_en_i = '0;
  logic [2:0]  mode_o;
  logic        wake_o, sub_ce_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpm_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i), .ssby_i(ssby_i),
    .lson_i(lson_i), .tw_en_i(tw_en_i), .div_sel_i(div_sel_i),
    .imask_i(imask_i), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
    .mode_o(mode_o), .wake_o(wake_o), .sub_ce_o(sub_ce_o)
  );

  typedef struct packed {
    logic        rst;
    logic        slp;
    logic        ssby;
    logic        lson;
    logic        tw;
    logic        msk;
    logic [15:0] irq;
    logic [15:0] en;
    logic [2:0]  mode;
    logic        wake;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,3'd1,1'b0,4'd3},  // R3 active -> sleep
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0002,16'hFFFF,3'd1,1'b0,4'd2},  // R2 masked
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0002,16'hFFFD,3'd1,1'b0,4'd2},  // R2 disabled
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0002,16'hFFFF,3'd0,1'b1,4'd4},  // R4 wake to active
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,3'd0,1'b0,4'd9},  // R9 pulse ends
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,3'd2,1'b0,4'd3},  // R3 -> standby
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'hFFFF,3'd2,1'b0,4'd5},  // R5 no irq exit
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,3'd2,1'b0,4'd11}, // R11 sleep ignored
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,3'd0,1'b0,4'd1},  // R1 reset
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h0000,3'd3,1'b0,4'd3},  // R3 -> watch
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0002,16'hFFFF,3'd3,1'b0,4'd6},  // R6 timer C refused
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0008,16'hFFFF,3'd5,1'b1,4'd6},  // R6 IRQ0 -> subactive
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,3'd5,1'b0,4'd8},  // R8 stays
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,3'd5,1'b0,4'd8},  // R8 stays
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0000,16'h0000,3'd4,1'b0,4'd8},  // R8 -> subsleep
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0004,16'hFFFF,3'd4,1'b0,4'd2},  // R2 masked
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0004,16'hFFFF,3'd5,1'b1,4'd7},  // R7 timer G
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h0000,3'd3,1'b0,4'd8},  // R8 -> watch
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,3'd3,1'b0,4'd11}, // R11 sleep ignored
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0100,16'hFFFF,3'd0,1'b1,4'd6},  // R6 pin0, lson=0
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'hFFFF,3'd0,1'b0,4'd11}, // R11 irq in active
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0000,16'h0000,3'd4,1'b0,4'd3},  // R3 -> subsleep
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0080,16'hFFFF,3'd5,1'b1,4'd7},  // R7 IRQ4
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h0000,3'd3,1'b0,4'd8},  // R8 -> watch
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h8000,16'hFFFF,3'd5,1'b1,4'd6},  // R6 pin7
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,3'd0,1'b0,4'd1}   // R1 reset from subactive
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sleep_i = 1'b0; ssby_i = 1'b0; lson_i = 1'b0; tw_en_i = 1'b0;
    imask_i = 1'b0; irq_req_i = '0; irq_en_i = '0;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_ce(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sub_ce_o) c++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int c;
    repeat (3) @(negedge clk);
    chk(mode_o == 3'd0, "R1 reset mode", mode_o, 0);
    chk(wake_o == 1'b0, "R1 reset wake", wake_o, 0);
    chk(sub_ce_o == 1'b0, "R1 reset ce", sub_ce_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].rst) begin
        idle_inputs();
        rst_ni = 1'b0;
      end else begin
        sleep_i = VEC[k].slp; ssby_i = VEC[k].ssby; lson_i = VEC[k].lson;
        tw_en_i = VEC[k].tw; imask_i = VEC[k].msk;
        irq_req_i = VEC[k].irq; irq_en_i = VEC[k].en;
      end
      cycle();
      if (mode_o != VEC[k].mode)
        chk(1'b0, $sformatf("R%0d mode step %0d", VEC[k].req, k), mode_o, VEC[k].mode);
      else chk(1'b1, "", 0, 0);
      if (wake_o != VEC[k].wake)
        chk(1'b0, $sformatf("R%0d wake step %0d", VEC[k].req, k), wake_o, VEC[k].wake);
      else chk(1'b1, "", 0, 0);
      rst_ni = 1'b1;
      idle_inputs();
    end

    // R10: no enable outside subactive
    div_sel_i = 2'd0;
    count_ce(16, c);
    chk(c == 0, "R10 ce in active", c, 0);

    // reach subactive via watch and timer A, then hold the request for a second cycle
    sleep_i = 1'b1; ssby_i = 1'b1; tw_en_i = 1'b1;
    cycle();
    idle_inputs();
    lson_i = 1'b1; irq_req_i = 16'h0001; irq_en_i = 16'h0001;
    cycle();
    chk(mode_o == 3'd5, "R6 timer A to subactive", mode_o, 5);
    chk(wake_o == 1'b1, "R9 wake raised", wake_o, 1);
    cycle();
    chk(wake_o == 1'b0, "R9 wake single cycle", wake_o, 0);
    chk(mode_o == 3'd5, "R11 irq in subactive", mode_o, 5);
    idle_inputs();

    for (int s = 0; s < 4; s++) begin
      int exp_c;
      div_sel_i = 2'(s);
      exp_c = (s == 0) ? 8 : (s == 1) ? 4 : 2;
      count_ce(16, c);
      chk(c == exp_c, $sformatf("R10 ce count sel=%0d", s), c, exp_c);
    end

    // R1: async reset from subactive clears mode and enable at once
    #1 rst_ni = 1'b0;
    #0.5;
    chk(mode_o == 3'd0, "R1 async reset", mode_o, 0);
    chk(sub_ce_o == 1'b0, "R1 ce cleared", sub_ce_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule